// File: doc/BRIEF.md
# Write-Only I2C Segment Display Slave

This block receives display traffic over a two-wire I2C bus that has already been synchronised to the system clock. It tracks START and STOP conditions and matches a 7-bit device address. It acknowledges accepted bytes on a dedicated open-drain output. It then walks the byte stream through a control-byte protocol. Each control byte says whether the next byte is a command or display data, and whether another control byte will follow it.

Command bytes are passed, one clock pulse each, to the command decoder that the three-wire serial interface also uses. Display data bytes are packed, eight segments per byte, into an 80-segment row buffer. The first byte of a row goes to the highest segment group. When the row is full, it is presented together with a one-cycle write strobe. The downstream decoder then stores it in the row latch that its last address command selected. The block only accepts writes: reads, clock stretching and analog glitch filtering are not part of it.

Top module: `segi2c_slave`

## Requirements
- R1: After reset, `ackOdN` is 1, `cmdValid` and `rowWrite` are 0 and `rowData` is all zeros.
- R2: After a START, an address byte equal to `{0,1,1,0,0,strapAddr[1],strapAddr[0],0}` (MSB first, last bit being the direction bit) is acknowledged. `ackOdN` goes low after the SCL falling edge that ends the eighth bit. It returns high after the SCL falling edge that ends the ninth (acknowledge) clock. Every following control, command and data byte is acknowledged the same way.
- R3: An address byte that differs from R2, or that has the direction bit set to 1, is not acknowledged. Every following byte up to the next START produces no acknowledge, no `cmdValid` and no `rowWrite`.
- R4: The byte after an accepted address is a control byte. Bit 7 (continue flag): 1 means a control byte follows the next byte, 0 means this is the last control byte. Bit 6 (data select): 0 means command, 1 means display data. Bits 5..0 have no effect.
- R5: A command byte raises `cmdValid` for exactly one clock, with `cmdByte` equal to the received byte. The pulse comes one clock after the clock edge on which the SCL rise of the byte's last bit is sampled.
- R6: The k-th display byte of a row (k = 0..9) is written to `rowData[(9-k)*8 +: 8]`, byte bit 0 going to the lowest segment of the group (`rowData` bit 0 is segment 1; 1 = on). After the tenth byte, `rowWrite` pulses for one clock with the full row on `rowData` and the byte index wraps to 0. `rowData` does not change at any other time.
- R7: After a control byte with the continue flag at 0, every byte up to the next START or STOP is handled with that control byte's data select. After one with the flag at 1, exactly one payload byte is taken before the next control byte.
- R8: A repeated START restarts address matching but keeps a partly filled row. A STOP discards a partly filled row, so the next display byte lands in the top group.
- R9: A START or STOP condition releases `ackOdN` to 1 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised bus clock |
| sdaIn | input | 1 | Synchronised bus data |
| strapAddr | input | 2 | Strap pins forming the two low address bits |
| ackOdN | output | 1 | Open-drain acknowledge, 0 = pull low |
| cmdValid | output | 1 | One-cycle strobe for a received command |
| cmdByte | output | 8 | Received command byte |
| rowWrite | output | 1 | One-cycle strobe, full display row ready |
| rowData | output | 80 | Segment row, bit 0 = segment 1 |

## Verification
The hardest situation to reach from the ports is a row that is partly filled when the bus framing changes. One case has a repeated START in mid-row, which must keep the row position. The other has a STOP after an eleventh byte, which must throw the stray byte away. The stimulus reaches both with single-byte data payloads interleaved with commands. A data byte sent under a control byte with the continue flag set, then two commands and a repeated START, leaves the row buffer holding one byte. Nine more bytes must then complete the row with the stranded byte in the top group. A behavioural model fed from the same bus wires predicts acknowledge, command and row outputs every clock.

// File: rtl/segi2c_pkg.sv
package segi2c_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CTRL,
    PH_PAYLOAD
  } busPhase_t;

  typedef struct packed {
    logic shiftBit;
    logic storeData;
    logic issueCmd;
    logic clearRow;
  } dpStrobe_t;

endpackage

// File: rtl/segi2c_ctrl.sv
module segi2c_ctrl
  import segi2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7,
  parameter int STRAP_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 5'b01100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [BYTE_W-1:0]  nextByte,
  output dpStrobe_t          strobe,
  output logic               ackOdN
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  busPhase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic sclQ, sdaQ;
  logic ackPend, isData, lastCtrl;
  logic sclRise, sclFall, startSeen, stopSeen, byteEnd, addrHit;

  always_comb begin
    sclRise   = sclIn & ~sclQ;
    sclFall   = ~sclIn & sclQ;
    startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
    stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
    byteEnd   = sclRise && (bitCnt == LAST_BIT) && (phase != PH_IDLE);
    addrHit   = (nextByte[BYTE_W-1:1] == {ADDR_PREFIX, strapAddr}) && !nextByte[0];
    strobe           = '0;
    strobe.shiftBit  = sclRise && (bitCnt < ACK_SLOT);
    strobe.storeData = byteEnd && (phase == PH_PAYLOAD) && isData;
    strobe.issueCmd  = byteEnd && (phase == PH_PAYLOAD) && !isData;
    strobe.clearRow  = stopSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      ackPend  <= 1'b0;
      isData   <= 1'b0;
      lastCtrl <= 1'b0;
      ackOdN   <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startSeen || stopSeen) begin
        phase   <= startSeen ? PH_ADDR : PH_IDLE;
        bitCnt  <= '0;
        ackPend <= 1'b0;
        ackOdN  <= 1'b1;
      end else begin
        if (sclRise) begin
          bitCnt <= (bitCnt == ACK_SLOT) ? '0 : bitCnt + 1'b1;
        end
        if (byteEnd) begin
          unique case (phase)
            PH_ADDR: begin
              ackPend <= addrHit;
              phase   <= addrHit ? PH_CTRL : PH_IDLE;
            end
            PH_CTRL: begin
              ackPend  <= 1'b1;
              isData   <= nextByte[BYTE_W-2];
              lastCtrl <= ~nextByte[BYTE_W-1];
              phase    <= PH_PAYLOAD;
            end
            PH_PAYLOAD: begin
              ackPend <= 1'b1;
              if (!lastCtrl) phase <= PH_CTRL;
            end
            default: ackPend <= 1'b0;
          endcase
        end
        if (sclFall) begin
          ackOdN <= (bitCnt == ACK_SLOT) ? ~ackPend : 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/segi2c_datapath.sv
module segi2c_datapath
  import segi2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEG_COUNT = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaIn,
  input  dpStrobe_t            strobe,
  output logic [BYTE_W-1:0]    nextByte,
  output logic                 cmdValid,
  output logic [BYTE_W-1:0]    cmdByte,
  output logic                 rowWrite,
  output logic [SEG_COUNT-1:0] rowData
);

  localparam int GROUPS = SEG_COUNT / BYTE_W;
  localparam int IDX_W = $clog2(GROUPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUPS - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [IDX_W-1:0] byteIdx;
  logic [SEG_COUNT-1:0] rowBuf, merged;
  logic [GROUPS-1:0] groupHit;

  assign nextByte = {shiftReg[BYTE_W-2:0], sdaIn};

  // Byte k of a row targets group GROUPS-1-k: the top group is filled first.
  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    assign groupHit[g] = strobe.storeData && (byteIdx == IDX_W'(GROUPS - 1 - g));
    assign merged[g*BYTE_W +: BYTE_W] = groupHit[g] ? nextByte : rowBuf[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteIdx  <= '0;
      rowBuf   <= '0;
      cmdValid <= 1'b0;
      cmdByte  <= '0;
      rowWrite <= 1'b0;
      rowData  <= '0;
    end else begin
      if (strobe.shiftBit) shiftReg <= nextByte;
      cmdValid <= strobe.issueCmd;
      if (strobe.issueCmd) cmdByte <= nextByte;
      rowWrite <= 1'b0;
      rowBuf   <= merged;
      if (strobe.clearRow) begin
        byteIdx <= '0;
      end else if (strobe.storeData) begin
        if (byteIdx == LAST_IDX) begin
          byteIdx  <= '0;
          rowWrite <= 1'b1;
          rowData  <= merged;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/segi2c_slave.sv
module segi2c_slave
  import segi2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEG_COUNT = 80,
  parameter int STRAP_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [STRAP_W-1:0]   strapAddr,
  output logic                 ackOdN,
  output logic                 cmdValid,
  output logic [BYTE_W-1:0]    cmdByte,
  output logic                 rowWrite,
  output logic [SEG_COUNT-1:0] rowData
);

  dpStrobe_t strobe;
  logic [BYTE_W-1:0] nextByte;

  segi2c_ctrl #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .nextByte(nextByte),
    .strobe(strobe), .ackOdN(ackOdN)
  );

  segi2c_datapath #(.BYTE_W(BYTE_W), .SEG_COUNT(SEG_COUNT)) dp_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strobe(strobe),
    .nextByte(nextByte), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .rowWrite(rowWrite), .rowData(rowData)
  );

endmodule

// File: rtl/segi2c_checker.sv
module segi2c_checker #(
  parameter int SEG_COUNT = 80
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sclIn,
  input logic                 sdaIn,
  input logic                 ackOdN,
  input logic                 cmdValid,
  input logic                 rowWrite,
  input logic [SEG_COUNT-1:0] rowData
);

  logic sclD, sdaD, frameEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclIn;
      sdaD <= sdaIn;
    end
  end

  assign frameEdge = sclIn & sclD & (sdaD ^ sdaIn);

  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rstN) |-> ackOdN && !cmdValid && !rowWrite);

  assert_ack_on_scl_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOdN) |-> (!$past(sclIn) && $past(sclIn, 2)));

  assert_cmd_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_row_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rowWrite |=> !rowWrite);

  assert_row_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rowWrite |-> $stable(rowData));

  assert_cmd_row_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && rowWrite));

  assert_frame_releases_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameEdge |=> ackOdN);

endmodule

bind segi2c_slave segi2c_checker #(.SEG_COUNT(SEG_COUNT)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ackOdN(ackOdN),
  .cmdValid(cmdValid), .rowWrite(rowWrite), .rowData(rowData)
);

// File: tb/segi2c_slave_tb_top.sv
module segi2c_slave_tb_top;

  localparam int SEGS = 80;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic [1:0] strap = 2'b10;

  logic ackOdN, cmdValid, rowWrite;
  logic [7:0] cmdByte;
  logic [SEGS-1:0] rowData;

  segi2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .strapAddr(strap),
    .ackOdN(ackOdN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .rowWrite(rowWrite), .rowData(rowData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [SEGS-1:0] act, input logic [SEGS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, fed from the bench's own bus wires.
  int pScl, pSda, nb, mode, acc, isDat, lastC;
  int eAck, eCmdV, eRowW;
  logic [7:0] sh, eCmdB;
  logic [SEGS-1:0] eRow;
  logic [7:0] rowQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      pScl = 1; pSda = 1; nb = 0; mode = 0; acc = 0; isDat = 0; lastC = 0;
      eAck = 1; eCmdV = 0; eRowW = 0; sh = 0; eCmdB = 0; eRow = '0;
      rowQ.delete();
    end else begin
      eCmdV = 0;
      eRowW = 0;
      if (scl && pScl == 1 && pSda == 1 && !sda) begin
        mode = 1; nb = 0; acc = 0; eAck = 1;
      end else if (scl && pScl == 1 && pSda == 0 && sda) begin
        mode = 0; nb = 0; acc = 0; eAck = 1; rowQ.delete();
      end else begin
        if (scl && pScl == 0) begin
          if (nb < 8) sh = {sh[6:0], sda};
          if (nb == 7 && mode != 0) begin
            case (mode)
              1: if (sh == {5'b01100, strap, 1'b0}) begin mode = 2; acc = 1; end
                 else begin mode = 0; acc = 0; end
              2: begin acc = 1; isDat = sh[6]; lastC = !sh[7]; mode = 3; end
              default: begin
                acc = 1;
                if (isDat != 0) begin
                  rowQ.push_back(sh);
                  if (rowQ.size() == 10) begin
                    for (int k = 0; k < 10; k++) eRow[(9-k)*8 +: 8] = rowQ[k];
                    eRowW = 1;
                    rowQ.delete();
                  end
                end else begin
                  eCmdV = 1; eCmdB = sh;
                end
                if (lastC == 0) mode = 2;
              end
            endcase
          end
          nb = (nb == 8) ? 0 : nb + 1;
        end
        if (!scl && pScl == 1) eAck = (nb == 8) ? ((acc != 0) ? 0 : 1) : 1;
      end
      pScl = scl;
      pSda = sda;
    end
  end

  int nCmd = 0, nRow = 0;
  logic [7:0] lastCmd = 8'h00;

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(ackOdN == eAck[0], "R2", "ackOdN vs model", SEGS'(ackOdN), SEGS'(eAck));
      check(cmdValid == eCmdV[0], "R5", "cmdValid vs model", SEGS'(cmdValid), SEGS'(eCmdV));
      if (eCmdV != 0) check(cmdByte == eCmdB, "R5", "cmdByte vs model", SEGS'(cmdByte), SEGS'(eCmdB));
      check(rowWrite == eRowW[0], "R6", "rowWrite vs model", SEGS'(rowWrite), SEGS'(eRowW));
      check(rowData == eRow, "R6", "rowData vs model", rowData, eRow);
      if (cmdValid) begin nCmd++; lastCmd = cmdByte; end
      if (rowWrite) nRow++;
    end
  end

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic busStart();
    sda = 1'b1; hold();
    scl = 1'b1; hold();
    sda = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic busStop();
    sda = 1'b0; hold();
    scl = 1'b1; hold();
    sda = 1'b1; hold();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; hold();
      scl = 1'b1; hold();
      scl = 1'b0; hold();
    end
    sda = 1'b1; hold();
    scl = 1'b1; hold();
    acked = !ackOdN;
    scl = 1'b0; hold();
  endtask

  function automatic logic [7:0] patA(input int k);
    return 8'(8'h5A + k * 37);
  endfunction

  initial begin
    bit a;
    logic [SEGS-1:0] expRow;
    int cmdBase, rowBase;

    repeat (5) @(negedge clk);
    check(ackOdN == 1'b1 && !cmdValid && !rowWrite, "R1", "reset strobes", SEGS'({ackOdN, cmdValid, rowWrite}), SEGS'(3'b100));
    check(rowData == '0, "R1", "reset rowData", rowData, '0);
    rstN = 1'b1;
    hold();

    // Address match, command, control byte with junk low bits, a full row plus a stray byte.
    busStart();
    sendByte(8'h64, a); check(a, "R2", "address ack", SEGS'(a), 1);
    sendByte(8'h80, a); check(a, "R4", "control ack", SEGS'(a), 1);
    sendByte(8'hC5, a); check(a, "R2", "command ack", SEGS'(a), 1);
    sendByte(8'h55, a); check(a, "R4", "control with ignored bits ack", SEGS'(a), 1);
    expRow = '0;
    for (int k = 0; k < 10; k++) begin
      sendByte(patA(k), a);
      expRow[(9-k)*8 +: 8] = patA(k);
    end
    check(nCmd == 1 && lastCmd == 8'hC5, "R5", "command delivered", SEGS'(lastCmd), SEGS'(8'hC5));
    check(nRow == 1, "R6", "one row write", SEGS'(nRow), 1);
    check(rowData == expRow, "R6", "row byte placement", rowData, expRow);
    sendByte(8'hFF, a);
    busStop();
    hold();
    check(ackOdN == 1'b1, "R9", "ack released after stop", SEGS'(ackOdN), 1);

    // STOP discarded the stray byte: a fresh row must start at the top group.
    busStart();
    sendByte(8'h64, a);
    sendByte(8'h40, a);
    for (int k = 0; k < 10; k++) begin
      sendByte(~patA(k), a);
      expRow[(9-k)*8 +: 8] = ~patA(k);
    end
    check(nRow == 2 && rowData == expRow, "R8", "stop discards partial row", rowData, expRow);
    busStop();

    // Wrong address, then read direction: no acknowledge, nothing delivered.
    cmdBase = nCmd;
    busStart();
    sendByte(8'h66, a); check(!a, "R3", "wrong address not acked", SEGS'(a), 0);
    sendByte(8'h00, a); check(!a, "R3", "ignored control not acked", SEGS'(a), 0);
    sendByte(8'h33, a); check(!a, "R3", "ignored command not acked", SEGS'(a), 0);
    busStop();
    busStart();
    sendByte(8'h65, a); check(!a, "R3", "read direction not acked", SEGS'(a), 0);
    sendByte(8'h00, a);
    sendByte(8'h12, a); check(!a, "R3", "bytes after read request ignored", SEGS'(a), 0);
    busStop();
    check(nCmd == cmdBase, "R3", "no command from ignored frames", SEGS'(nCmd), SEGS'(cmdBase));

    // One data byte, back-to-back commands, repeated START keeps the partial row.
    rowBase = nRow;
    busStart();
    sendByte(8'h64, a);
    sendByte(8'hC0, a);
    sendByte(8'h81, a);
    sendByte(8'h00, a); check(a, "R7", "second control after continue flag", SEGS'(a), 1);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    check(nCmd == cmdBase + 2 && lastCmd == 8'h22, "R7", "back-to-back commands", SEGS'(lastCmd), SEGS'(8'h22));
    busStart();
    sendByte(8'h64, a); check(a, "R8", "address after repeated start", SEGS'(a), 1);
    sendByte(8'h40, a);
    expRow = '0;
    expRow[79:72] = 8'h81;
    for (int k = 1; k < 10; k++) begin
      sendByte(patA(k + 3), a);
      expRow[(9-k)*8 +: 8] = patA(k + 3);
    end
    check(nRow == rowBase + 1 && rowData == expRow, "R8", "repeated start keeps row position", rowData, expRow);
    busStop();

    // Other strap value, alternating control and command bytes.
    strap = 2'b01;
    hold();
    busStart();
    sendByte(8'h62, a); check(a, "R2", "strap address ack", SEGS'(a), 1);
    sendByte(8'h80, a);
    sendByte(8'h5A, a);
    sendByte(8'h3F, a);
    sendByte(8'h6B, a);
    sendByte(8'h7C, a);
    check(nCmd == cmdBase + 5 && lastCmd == 8'h7C, "R4", "commands after control with ignored bits", SEGS'(lastCmd), SEGS'(8'h7C));
    busStop();
    busStart();
    sendByte(8'h64, a); check(!a, "R3", "old strap address not acked", SEGS'(a), 0);
    busStop();
    hold();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule